// File: doc/BRIEF.md
# Flash Status Register with Sticky Errors

This block holds the 8-bit status word of an embedded flash command interface. A write state machine feeds it with level signals and single-cycle event pulses. The level signals are busy, program suspend, erase suspend, buffered-programming mode and buffer occupancy. The event pulses are erase failure, program failure, low programming voltage, locked-block abort and command sequence error. The host reads the word combinationally from a register that updates on every rising clock edge.

The word has two kinds of bit. Live bits (7, 6, 2, 0) are recomputed from the state machine's present condition every cycle. They come from a small state machine that sorts the inputs into one of seven named conditions. Error bits (5, 4, 3, 1) are set by event pulses and stay set until the host issues a clear-status strobe or the block is reset. An old error therefore hides later outcomes, and the host is expected to clear the word before starting a new operation.

Live condition states and transitions: `LV_READY` (idle), `LV_BUSY` (busy, not buffered), `LV_BUF_OPEN` (busy, buffered mode, buffer free), `LV_BUF_HELD` (busy, buffered mode, buffer not available), `LV_ERS_SUSP` (idle with erase suspended), `LV_PRG_SUSP` (idle with program suspended), `LV_DUAL_SUSP` (idle with both suspended). Each cycle the next state is chosen from the inputs alone, so any state may move to any other. Busy has priority: while busy is high, one of the three busy states is chosen, by buffered mode and buffer occupancy. While busy is low, the suspend levels choose among the four idle states. Reset enters `LV_READY`.

Top module: `flash_status_reg`

## Requirements
- R1: A synchronous active-high reset makes the status word read 0x80 on the cycle after the reset edge.
- R2: Bit 7 reads 1 one cycle after the busy input is sampled low, and 0 one cycle after it is sampled high.
- R3: Bit 6 reads 1 when erase suspend is sampled high, and bit 2 reads 1 when program suspend is sampled high, in both cases only while busy is low. Both bits may be 1 at once, and each returns to 0 when its level drops.
- R4: An erase-failure pulse sets bit 5 and a program-failure pulse sets bit 4. Each bit stays 1 on every later cycle until a clear strobe or a reset.
- R5: A command-sequence-error pulse sets bits 5 and 4 together. When it arrives while the state machine is idle, the word shows bits 7, 5 and 4 all set.
- R6: A low-programming-voltage pulse sets bit 3 and a locked-block-abort pulse sets bit 1. Both bits are sticky in the same way as R4.
- R7: A clear strobe with no set event in the same cycle returns bits 5, 4, 3 and 1 to 0 on the next cycle. No voltage condition blocks it, and it leaves the live bits unchanged.
- R8: When a clear strobe and a set event fall in the same cycle, the bit named by the event reads 1 afterwards. The other error bits read 0.
- R9: Bit 0 reads 1 only while busy, buffered mode and buffer-not-available are all sampled high, and reads 0 otherwise. The pair (bit 7, bit 0) never reads 11.
- R10: An error latched during an erase suspend is still set after the erase resumes and completes. A later erase failure then leaves the word unchanged unless a clear came between.
- R11: Error bits are not changed by the live inputs, and live bits are not changed by event pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wsm_busy | input | 1 | State machine busy level |
| prg_susp | input | 1 | Program suspend in effect |
| ers_susp | input | 1 | Erase suspend in effect |
| buf_mode | input | 1 | Buffered-programming mode active |
| buf_full | input | 1 | Program buffer not available for loading |
| ev_ers_fail | input | 1 | Erase failure pulse |
| ev_prg_fail | input | 1 | Program failure pulse |
| ev_vpp_low | input | 1 | Programming voltage below lockout pulse |
| ev_lock_abort | input | 1 | Operation aborted on locked block pulse |
| ev_seq_err | input | 1 | Command sequence error pulse |
| clr_stat | input | 1 | Clear-status command strobe |
| status | output | 8 | Status word |

## Verification
The hardest situation to reach from the ports is a clear strobe in the same cycle as a set event, while other error bits are already latched from earlier. The bench reaches it by sweeping every preloaded error pattern against every combination of the five event pulses, with and without the strobe. Each run starts from reset and preloads the pattern with its own pulses. The stale-error scenario is driven as an explicit sequence: suspend, sequence error, resume, erase failure, then clear and fail again.

// File: rtl/flash_status_pkg.sv
`timescale 1ns/1ps
package flash_status_pkg;
    localparam int STATUS_W   = 8;
    localparam int N_STICKY   = 4;
    // bit positions of the status word
    localparam int B_READY    = 7;
    localparam int B_ERS_SUSP = 6;
    localparam int B_ERS_ERR  = 5;
    localparam int B_PRG_ERR  = 4;
    localparam int B_VPP_ERR  = 3;
    localparam int B_PRG_SUSP = 2;
    localparam int B_LOCK_ERR = 1;
    localparam int B_BUF_HELD = 0;
    localparam logic [STATUS_W-1:0] RESET_WORD = STATUS_W'(1) << B_READY;
    // index of each sticky bit inside the sticky bank
    localparam int K_ERS  = 0;
    localparam int K_PRG  = 1;
    localparam int K_VPP  = 2;
    localparam int K_LOCK = 3;

    typedef enum logic [2:0] {
        LV_READY     = 3'd0,
        LV_BUSY      = 3'd1,
        LV_BUF_OPEN  = 3'd2,
        LV_BUF_HELD  = 3'd3,
        LV_ERS_SUSP  = 3'd4,
        LV_PRG_SUSP  = 3'd5,
        LV_DUAL_SUSP = 3'd6
    } live_state_t;

    typedef struct packed {
        logic ready;
        logic ers_susp;
        logic prg_susp;
        logic buf_held;
    } live_bits_t;
endpackage

// File: rtl/status_live_fsm.sv
`timescale 1ns/1ps
module status_live_fsm
    import flash_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wsm_busy,
    input  logic       prg_susp,
    input  logic       ers_susp,
    input  logic       buf_mode,
    input  logic       buf_full,
    output live_bits_t live
);
    live_state_t state_q, state_d;

    // next-state choice: busy has priority, then suspend levels
    always_comb begin
        if (wsm_busy) begin
            if (!buf_mode)     state_d = LV_BUSY;
            else if (buf_full) state_d = LV_BUF_HELD;
            else               state_d = LV_BUF_OPEN;
        end else begin
            unique case ({prg_susp, ers_susp})
                2'b11:   state_d = LV_DUAL_SUSP;
                2'b10:   state_d = LV_PRG_SUSP;
                2'b01:   state_d = LV_ERS_SUSP;
                default: state_d = LV_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LV_READY;
        else     state_q <= state_d;
    end

    // output decode
    always_comb begin
        live = '0;
        unique case (state_q)
            LV_READY:     live.ready = 1'b1;
            LV_BUSY:      live = '0;
            LV_BUF_OPEN:  live = '0;
            LV_BUF_HELD:  live.buf_held = 1'b1;
            LV_ERS_SUSP:  begin live.ready = 1'b1; live.ers_susp = 1'b1; end
            LV_PRG_SUSP:  begin live.ready = 1'b1; live.prg_susp = 1'b1; end
            LV_DUAL_SUSP: begin
                live.ready    = 1'b1;
                live.ers_susp = 1'b1;
                live.prg_susp = 1'b1;
            end
            default:      live.ready = 1'b1;
        endcase
    end
endmodule

// File: rtl/status_sticky_cell.sv
`timescale 1ns/1ps
module status_sticky_cell (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    // set has priority over clear so a new error is never lost
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/status_sticky_bank.sv
`timescale 1ns/1ps
module status_sticky_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        status_sticky_cell u_cell (
            .clk (clk),
            .rst (rst),
            .set (set[i]),
            .clr (clr),
            .q   (q[i])
        );
    end
endmodule

// File: rtl/flash_status_reg.sv
`timescale 1ns/1ps
module flash_status_reg
    import flash_status_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wsm_busy,
    input  logic                prg_susp,
    input  logic                ers_susp,
    input  logic                buf_mode,
    input  logic                buf_full,
    input  logic                ev_ers_fail,
    input  logic                ev_prg_fail,
    input  logic                ev_vpp_low,
    input  logic                ev_lock_abort,
    input  logic                ev_seq_err,
    input  logic                clr_stat,
    output logic [STATUS_W-1:0] status
);
    live_bits_t          live;
    logic [N_STICKY-1:0] sticky_set;
    logic [N_STICKY-1:0] sticky_q;

    status_live_fsm u_live (
        .clk      (clk),
        .rst      (rst),
        .wsm_busy (wsm_busy),
        .prg_susp (prg_susp),
        .ers_susp (ers_susp),
        .buf_mode (buf_mode),
        .buf_full (buf_full),
        .live     (live)
    );

    // a sequence error marks both the erase and program error bits
    always_comb begin
        sticky_set         = '0;
        sticky_set[K_ERS]  = ev_ers_fail | ev_seq_err;
        sticky_set[K_PRG]  = ev_prg_fail | ev_seq_err;
        sticky_set[K_VPP]  = ev_vpp_low;
        sticky_set[K_LOCK] = ev_lock_abort;
    end

    status_sticky_bank #(.N(N_STICKY)) u_sticky (
        .clk (clk),
        .rst (rst),
        .set (sticky_set),
        .clr (clr_stat),
        .q   (sticky_q)
    );

    always_comb begin
        status             = '0;
        status[B_READY]    = live.ready;
        status[B_ERS_SUSP] = live.ers_susp;
        status[B_PRG_SUSP] = live.prg_susp;
        status[B_BUF_HELD] = live.buf_held;
        status[B_ERS_ERR]  = sticky_q[K_ERS];
        status[B_PRG_ERR]  = sticky_q[K_PRG];
        status[B_VPP_ERR]  = sticky_q[K_VPP];
        status[B_LOCK_ERR] = sticky_q[K_LOCK];
    end
endmodule

// File: rtl/flash_status_reg_chk.sv
`timescale 1ns/1ps
module flash_status_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       wsm_busy,
    input logic       ev_ers_fail,
    input logic       ev_prg_fail,
    input logic       ev_vpp_low,
    input logic       ev_lock_abort,
    input logic       ev_seq_err,
    input logic       clr_stat,
    input logic [7:0] status
);
    logic       any_set;
    logic [7:0] err_mask;
    assign any_set  = ev_ers_fail | ev_prg_fail | ev_vpp_low | ev_lock_abort | ev_seq_err;
    assign err_mask = 8'b0011_1010;

    // R1
    reset_word_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> status == 8'h80);

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(clr_stat)) |-> ((status & err_mask & $past(status)) == ($past(status) & err_mask)));

    // R5
    seq_err_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ev_seq_err)) |-> (status[5] && status[4]));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(clr_stat) && !$past(any_set)) |-> ((status & err_mask) == 8'h00));

    // R2
    ready_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (status[7] == !$past(wsm_busy)));

    // R9
    buf_code_chk: assert property (@(posedge clk) disable iff (rst)
        !(status[7] && status[0]));

    // R3
    susp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (status[6] || status[2]) |-> status[7]);
endmodule

bind flash_status_reg flash_status_reg_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wsm_busy      (wsm_busy),
    .ev_ers_fail   (ev_ers_fail),
    .ev_prg_fail   (ev_prg_fail),
    .ev_vpp_low    (ev_vpp_low),
    .ev_lock_abort (ev_lock_abort),
    .ev_seq_err    (ev_seq_err),
    .clr_stat      (clr_stat),
    .status        (status)
);

// File: tb/tb_flash_status_reg.sv
`timescale 1ns/1ps
module tb_flash_status_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wsm_busy = 1'b0, prg_susp = 1'b0, ers_susp = 1'b0;
    logic       buf_mode = 1'b0, buf_full = 1'b0;
    logic       ev_ers_fail = 1'b0, ev_prg_fail = 1'b0, ev_vpp_low = 1'b0;
    logic       ev_lock_abort = 1'b0, ev_seq_err = 1'b0, clr_stat = 1'b0;
    logic [7:0] status;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    flash_status_reg dut (
        .clk(clk), .rst(rst), .wsm_busy(wsm_busy), .prg_susp(prg_susp),
        .ers_susp(ers_susp), .buf_mode(buf_mode), .buf_full(buf_full),
        .ev_ers_fail(ev_ers_fail), .ev_prg_fail(ev_prg_fail),
        .ev_vpp_low(ev_vpp_low), .ev_lock_abort(ev_lock_abort),
        .ev_seq_err(ev_seq_err), .clr_stat(clr_stat), .status(status)
    );

    task automatic check(input string tag, input logic [7:0] exp);
        n_chk++;
        if (status !== exp) begin
            n_bad++;
            $display("FAIL %s: status=%02h expected=%02h", tag, status, exp);
        end
    endtask

    // drive after a falling edge, let one rising edge pass, sample at next falling edge
    task automatic tick;
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1'b1; tick(); rst = 1'b0;
    endtask

    task automatic live_in(input logic [4:0] v);
        {wsm_busy, prg_susp, ers_susp, buf_mode, buf_full} = v;
    endtask

    // events: e[0] erase fail, e[1] program fail, e[2] vpp low, e[3] lock abort, e[4] seq error
    task automatic events(input logic [4:0] e, input logic c);
        {ev_seq_err, ev_lock_abort, ev_vpp_low, ev_prg_fail, ev_ers_fail} = e;
        clr_stat = c;
        tick();
        {ev_seq_err, ev_lock_abort, ev_vpp_low, ev_prg_fail, ev_ers_fail} = '0;
        clr_stat = 1'b0;
    endtask

    function automatic logic [7:0] err_of(input logic [4:0] e);
        err_of = '0;
        err_of[5] = e[0] | e[4];
        err_of[4] = e[1] | e[4];
        err_of[3] = e[2];
        err_of[1] = e[3];
    endfunction

    function automatic logic [7:0] live_of(input logic [4:0] v);
        logic b, ps, es, bm, bf;
        {b, ps, es, bm, bf} = v;
        live_of = '0;
        live_of[7] = !b;
        live_of[6] = !b & es;
        live_of[2] = !b & ps;
        live_of[0] = b & bm & bf;
    endfunction

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset word
        check("R1 reset", 8'h80);

        // R2 R3 R9 sweep of all live input combinations, with errors preloaded (R11)
        events(5'b01111, 1'b0);
        for (int v = 0; v < 32; v++) begin
            live_in(5'(v));
            tick();
            check("R2/R3/R9/R11 live sweep", live_of(5'(v)) | 8'h3A);
        end
        live_in('0); tick();
        // R11 live bits unaffected by events
        events(5'b10000, 1'b0);
        check("R11 events keep live bits", 8'hBA);

        // R4 R5 R6 R7 R8 sweep: preload p, then event e with or without clear
        for (int p = 0; p < 32; p++) begin
            for (int e = 0; e < 32; e++) begin
                for (int c = 0; c < 2; c++) begin
                    live_in('0);
                    do_reset();
                    events(5'(p), 1'b0);
                    check("R4/R5/R6 preload", 8'h80 | err_of(5'(p)));
                    events(5'(e), c[0]);
                    if (c == 0)
                        check("R4/R5/R6 accumulate", 8'h80 | err_of(5'(p)) | err_of(5'(e)));
                    else
                        check("R7/R8 clear vs set", 8'h80 | err_of(5'(e)));
                    tick();
                    if (c == 0)
                        check("R4 hold", 8'h80 | err_of(5'(p)) | err_of(5'(e)));
                end
            end
        end

        // R7 clear while busy leaves live bits, while vpp pulse absent
        do_reset();
        events(5'b00100, 1'b0);
        live_in(5'b10011);
        tick();
        check("R7 busy preload", 8'h09);
        events(5'b00000, 1'b1);
        check("R7 clear keeps live", 8'h01);

        // R10 stale sequence error across erase suspend and resume
        live_in('0);
        do_reset();
        live_in(5'b10000); tick();
        live_in(5'b00100); tick();
        check("R10 erase suspended", 8'hC0);
        events(5'b10000, 1'b0);
        check("R10 seq err in suspend", 8'hF0);
        live_in(5'b10000); tick();
        check("R10 resumed busy", 8'h30);
        events(5'b00001, 1'b0);
        live_in(5'b00000); tick();
        check("R10 fail hidden", 8'hB0);
        events(5'b00000, 1'b1);
        check("R10 cleared", 8'h80);
        events(5'b00001, 1'b0);
        check("R10 fail visible", 8'hA0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: status=%02h expected=done", status);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule